// File: doc/BRIEF.md
# Calendar Real-Time Clock Counter

This block keeps wall-clock time and a calendar date in two packed registers and advances them by one second on every cycle in which the one-second tick input is high. The time word holds hours, minutes and seconds. The date word holds the day of the month, the month, a year counted as an offset from a base year, and a leap flag. The leap flag is stored as written and is never computed. When the day rolls over, the month length comes from the month number and the stored leap flag. December rolls into January of the next year offset.

The host reads and writes through a simple register port. Writes are single-cycle strobes and reads are combinational from the address. A host write to the time or date register does not land at once. It waits out a parameterised commit latency that stands in for the crossing into the slow clock domain. During that wait a read-only control word shows a busy flag for that register, and reads still return the old value. Every field of a register changes on the same clock edge. A host that reads twice and gets the same value therefore knows it has a coherent snapshot.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset the control word reads 0, the time word reads 0 (00:00:00) and the date word reads 0x00000101 (day 1, month 1, year offset 0, leap flag clear).
- R2: Offset 0x08 reads the time word with seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. Offset 0x04 reads the date word with day in bits 4:0, month (1 to 12) in bits 11:8, year offset in bits 16+YEAR_W-1:16 and the leap flag in bit 16+YEAR_W. All other bits read 0, even if they were written as 1.
- R3: A cycle with the tick high adds one second. Without a tick, and with no commit pending, the time does not change.
- R4: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day. All of these changes land on one edge.
- R5: The day wraps to 1 and the month advances after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12.
- R6: In month 2 the last day is 29 when the leap flag is set and 28 when it is clear.
- R7: After day 31 of month 12 the date becomes day 1 of month 1 and the year offset goes up by one. The leap flag keeps its stored value.
- R8: A write to offset 0x08 sets control bit 8 for COMMIT_LAT cycles. Meanwhile reads return the old time. On the edge that clears the bit, the written time becomes visible.
- R9: A write to offset 0x04 sets control bit 7 for COMMIT_LAT cycles, with the same old-value-until-commit behaviour for the date.
- R10: A second write to a register whose busy flag is still set restarts the full latency, and the latest value is the one committed.
- R11: If the tick is high on the edge where a commit lands, the committed register takes the written value unchanged, and no carry passes from the time word into the date word on that edge.
- R12: Writes to the control word at 0x00 have no effect. An unmapped offset such as 0x0C reads 0.
- R13: The year offset wraps from its maximum (all ones) to 0 when December 31 rolls over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse per elapsed second |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busAddr | input | ADDR_W | Byte offset for reads and writes |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data for busAddr, combinational |

## Verification
The counting logic is driven from starting points just before each boundary. Seconds alone, seconds into minutes, full-day carry, 30-day and 31-day months, February with the leap flag set and clear, December, and the year at its maximum. Each one shows whether the right wrap limit and carry chain is picked. The write path is tried with a single write, a rewrite while still busy, and a write whose commit lands on a tick edge. These tell apart a design that commits too early or too late, one that keeps the first value, and one that lets the tick or the day carry override a commit. Writes with stray bits set and writes to the control offset show that only the defined fields hold state.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  // Register byte offsets on the host port
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_DATE = 8'h04;
  localparam logic [7:0] OFS_TIME = 8'h08;

  // Busy flag positions in the control word
  localparam int BUSY_TIME_BIT = 8;
  localparam int BUSY_DATE_BIT = 7;

  // Channel indices of the commit engine
  localparam int CH_TIME = 0;
  localparam int CH_DATE = 1;
  localparam int NUM_CH  = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadTime;
    logic loadDate;
    logic busyTime;
    logic busyDate;
  } ctrl_strobe_t;

  // Last day of a month, given the stored leap flag
  function automatic logic [4:0] monthDays(input logic [3:0] mon, input logic leap);
    logic [4:0] n;
    case (mon)
      4'd2:                      n = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   n = 5'd30;
      default:                   n = 5'd31;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int COMMIT_LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctrl_strobe_t      strobe,
  output logic [DATA_W-1:0] pendTime,
  output logic [DATA_W-1:0] pendDate
);

  localparam int CNT_W = (COMMIT_LAT < 2) ? 1 : $clog2(COMMIT_LAT);
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(COMMIT_LAT - 1);

  logic [NUM_CH-1:0] busyV;
  logic [NUM_CH-1:0] loadV;
  logic [DATA_W-1:0] pendV [NUM_CH];

  // One commit channel per host-writable register
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam logic [ADDR_W-1:0] CH_OFS =
      (ch == CH_TIME) ? ADDR_W'(OFS_TIME) : ADDR_W'(OFS_DATE);

    logic             hit;
    logic [CNT_W-1:0] cnt;

    assign hit      = wrEn && (wrAddr == CH_OFS);
    assign loadV[ch] = busyV[ch] && (cnt == '0) && !hit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyV[ch] <= 1'b0;
        cnt       <= '0;
        pendV[ch] <= '0;
      end else if (hit) begin
        // new write (also restarts an outstanding one)
        busyV[ch] <= 1'b1;
        cnt       <= CNT_START;
        pendV[ch] <= wrData;
      end else if (loadV[ch]) begin
        busyV[ch] <= 1'b0;
      end else if (busyV[ch]) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign strobe.loadTime = loadV[CH_TIME];
  assign strobe.loadDate = loadV[CH_DATE];
  assign strobe.busyTime = busyV[CH_TIME];
  assign strobe.busyDate = busyV[CH_DATE];
  assign pendTime        = pendV[CH_TIME];
  assign pendDate        = pendV[CH_DATE];

endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int YEAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  ctrl_strobe_t      strobe,
  input  logic [DATA_W-1:0] pendTime,
  input  logic [DATA_W-1:0] pendDate,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] timeWord,
  output logic [DATA_W-1:0] dateWord
);

  localparam int YEAR_LO  = 16;
  localparam int LEAP_POS = YEAR_LO + YEAR_W;

  // Stored fields
  logic [5:0]        sec, secNext;
  logic [5:0]        min, minNext;
  logic [4:0]        hr, hrNext;
  logic [4:0]        day, dayNext;
  logic [3:0]        mon, monNext;
  logic [YEAR_W-1:0] yr, yrNext;
  logic              leap, leapNext;

  logic secWrap, minWrap, hrWrap, dayLast, monLast, dayCarry;

  // Bits of the pending words that map to no field
  logic unusedPendBits;
  assign unusedPendBits = ^{pendTime[DATA_W-1:21], pendTime[15:14], pendTime[7:6],
                            pendDate[DATA_W-1:LEAP_POS+1], pendDate[15:12], pendDate[7:5]};

  always_comb begin
    secWrap  = (sec >= 6'd59);
    minWrap  = (min >= 6'd59);
    hrWrap   = (hr  >= 5'd23);
    dayLast  = (day >= monthDays(mon, leap));
    monLast  = (mon >= 4'd12);
    dayCarry = tick && !strobe.loadTime && secWrap && minWrap && hrWrap;

    secNext  = sec;
    minNext  = min;
    hrNext   = hr;
    dayNext  = day;
    monNext  = mon;
    yrNext   = yr;
    leapNext = leap;

    // Time word: commit wins over counting
    if (strobe.loadTime) begin
      secNext = pendTime[5:0];
      minNext = pendTime[13:8];
      hrNext  = pendTime[20:16];
    end else if (tick) begin
      secNext = secWrap ? 6'd0 : sec + 6'd1;
      if (secWrap) begin
        minNext = minWrap ? 6'd0 : min + 6'd1;
        if (minWrap) begin
          hrNext = hrWrap ? 5'd0 : hr + 5'd1;
        end
      end
    end

    // Date word: commit wins over the day carry
    if (strobe.loadDate) begin
      dayNext  = pendDate[4:0];
      monNext  = pendDate[11:8];
      yrNext   = pendDate[YEAR_LO +: YEAR_W];
      leapNext = pendDate[LEAP_POS];
    end else if (dayCarry) begin
      dayNext = dayLast ? 5'd1 : day + 5'd1;
      if (dayLast) begin
        monNext = monLast ? 4'd1 : mon + 4'd1;
        if (monLast) begin
          yrNext = yr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sec  <= '0;
      min  <= '0;
      hr   <= '0;
      day  <= 5'd1;
      mon  <= 4'd1;
      yr   <= '0;
      leap <= 1'b0;
    end else begin
      sec  <= secNext;
      min  <= minNext;
      hr   <= hrNext;
      day  <= dayNext;
      mon  <= monNext;
      yr   <= yrNext;
      leap <= leapNext;
    end
  end

  // Packed views of the two registers
  always_comb begin
    timeWord        = '0;
    timeWord[5:0]   = sec;
    timeWord[13:8]  = min;
    timeWord[20:16] = hr;

    dateWord                    = '0;
    dateWord[4:0]               = day;
    dateWord[11:8]              = mon;
    dateWord[YEAR_LO +: YEAR_W] = yr;
    dateWord[LEAP_POS]          = leap;
  end

  // Host read mux
  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(OFS_CTRL)) begin
      rdData[BUSY_TIME_BIT] = strobe.busyTime;
      rdData[BUSY_DATE_BIT] = strobe.busyDate;
    end else if (rdAddr == ADDR_W'(OFS_DATE)) begin
      rdData = dateWord;
    end else if (rdAddr == ADDR_W'(OFS_TIME)) begin
      rdData = timeWord;
    end
  end

endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int YEAR_W     = 8,
  parameter int COMMIT_LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWData,
  output logic [31:0]       busRData
);

  localparam int DATA_W = 32;

  ctrl_strobe_t      strobe;
  logic [DATA_W-1:0] pendTime, pendDate;
  logic [DATA_W-1:0] timeQ, dateQ;
  logic              busyTime, busyDate;

  assign busyTime = strobe.busyTime;
  assign busyDate = strobe.busyDate;

  rtc_cal_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .COMMIT_LAT(COMMIT_LAT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (busWrEn),
    .wrAddr  (busAddr),
    .wrData  (busWData),
    .strobe  (strobe),
    .pendTime(pendTime),
    .pendDate(pendDate)
  );

  rtc_cal_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .YEAR_W(YEAR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (secTick),
    .strobe  (strobe),
    .pendTime(pendTime),
    .pendDate(pendDate),
    .rdAddr  (busAddr),
    .rdData  (busRData),
    .timeWord(timeQ),
    .dateWord(dateQ)
  );

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker #(
  parameter int ADDR_W     = 8,
  parameter int YEAR_W     = 8,
  parameter int COMMIT_LAT = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              secTick,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       timeVal,
  input logic [31:0]       dateVal,
  input logic              busyTime,
  input logic              busyDate
);

  localparam int LEAP_POS = 16 + YEAR_W;

  logic wrTime, wrDate;
  assign wrTime = busWrEn && (busAddr == ADDR_W'(8'h08));
  assign wrDate = busWrEn && (busAddr == ADDR_W'(8'h04));

  // Cycles each busy flag has been high since its last write
  logic [15:0] runT, runD;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runT <= '0;
      runD <= '0;
    end else begin
      if (wrTime || !busyTime) runT <= '0;
      else if (runT != 16'hFFFF) runT <= runT + 16'd1;
      if (wrDate || !busyDate) runD <= '0;
      else if (runD != 16'hFFFF) runD <= runD + 16'd1;
    end
  end

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !busyTime) |=> $stable(timeVal));

  a_r3_sec_step: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !busyTime && (timeVal[5:0] < 6'd59)) |=>
      (timeVal[5:0] == $past(timeVal[5:0]) + 6'd1));

  a_r8_busy_on_write: assert property (@(posedge clk) disable iff (!rstN)
    wrTime |=> busyTime);

  a_r9_busy_on_write: assert property (@(posedge clk) disable iff (!rstN)
    wrDate |=> busyDate);

  a_r8_latency_bound: assert property (@(posedge clk) disable iff (!rstN)
    busyTime |-> (runT < 16'(COMMIT_LAT)));

  a_r9_latency_bound: assert property (@(posedge clk) disable iff (!rstN)
    busyDate |-> (runD < 16'(COMMIT_LAT)));

  a_r7_leap_kept: assert property (@(posedge clk) disable iff (!rstN)
    !busyDate |=> $stable(dateVal[LEAP_POS]));

endmodule

bind rtc_cal_top rtc_cal_checker #(
  .ADDR_W    (ADDR_W),
  .YEAR_W    (YEAR_W),
  .COMMIT_LAT(COMMIT_LAT)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .secTick (secTick),
  .busWrEn (busWrEn),
  .busAddr (busAddr),
  .timeVal (timeQ),
  .dateVal (dateQ),
  .busyTime(busyTime),
  .busyDate(busyDate)
);

// File: tb/rtc_cal_top_tb.sv
`timescale 1ns/1ps
module rtc_cal_top_tb;

  localparam int ADDR_W   = 8;
  localparam int YEAR_W   = 8;
  localparam int LAT      = 4;
  localparam int LEAP_POS = 16 + YEAR_W;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_DATE = 8'h04;
  localparam logic [7:0] A_TIME = 8'h08;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rtc_cal_top #(.ADDR_W(ADDR_W), .YEAR_W(YEAR_W), .COMMIT_LAT(LAT)) u_dut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData)
  );

  function automatic logic [31:0] mkTime(int h, int m, int s);
    return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  function automatic logic [31:0] mkDate(int y, int mo, int d, int lp);
    return (32'(lp) << LEAP_POS) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    busAddr = a;
    #0.5;
    v = busRData;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic tickN(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); secTick = 1'b1;
      @(negedge clk); secTick = 1'b0;
    end
  endtask

  task automatic setRegs(logic [31:0] t, logic [31:0] d);
    wr(A_TIME, t);
    wr(A_DATE, d);
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic rollCase(string tag, logic [31:0] t, logic [31:0] d,
                          logic [31:0] expT, logic [31:0] expD);
    logic [31:0] v;
    setRegs(t, d);
    tickN(1);
    rd(A_TIME, v); chk({tag, " time"}, v, expT);
    rd(A_DATE, v); chk({tag, " date"}, v, expD);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_TIME, v); chk("R1 time", v, 32'h0);
    rd(A_DATE, v); chk("R1 date", v, 32'h0000_0101);
  endtask

  task automatic testTick();
    logic [31:0] v;
    tickN(1);
    rd(A_TIME, v); chk("R3 one tick", v, mkTime(0, 0, 1));
    repeat (6) @(negedge clk);
    rd(A_TIME, v); chk("R3 no tick hold", v, mkTime(0, 0, 1));
    tickN(3);
    rd(A_TIME, v); chk("R3 three ticks", v, mkTime(0, 0, 4));
  endtask

  task automatic testLayout();
    logic [31:0] v;
    setRegs(mkTime(12, 34, 56) | 32'hFF00_C0C0, mkDate(40, 7, 15, 1) | 32'h0000_F0E0);
    rd(A_TIME, v); chk("R2 time fields", v, mkTime(12, 34, 56));
    rd(A_DATE, v); chk("R2 date fields", v, mkDate(40, 7, 15, 1));
  endtask

  task automatic testRollover();
    rollCase("R4 sec carry", mkTime(10, 20, 59), mkDate(10, 3, 5, 0),
             mkTime(10, 21, 0), mkDate(10, 3, 5, 0));
    rollCase("R4 hour carry", mkTime(10, 59, 59), mkDate(10, 3, 5, 0),
             mkTime(11, 0, 0), mkDate(10, 3, 5, 0));
    rollCase("R4 day carry", mkTime(23, 59, 59), mkDate(10, 3, 5, 0),
             mkTime(0, 0, 0), mkDate(10, 3, 6, 0));
    rollCase("R5 30-day month", mkTime(23, 59, 59), mkDate(10, 4, 30, 0),
             mkTime(0, 0, 0), mkDate(10, 5, 1, 0));
    rollCase("R5 day 30 of 31", mkTime(23, 59, 59), mkDate(10, 1, 30, 0),
             mkTime(0, 0, 0), mkDate(10, 1, 31, 0));
    rollCase("R5 31-day month", mkTime(23, 59, 59), mkDate(10, 8, 31, 0),
             mkTime(0, 0, 0), mkDate(10, 9, 1, 0));
    rollCase("R6 feb no leap", mkTime(23, 59, 59), mkDate(11, 2, 28, 0),
             mkTime(0, 0, 0), mkDate(11, 3, 1, 0));
    rollCase("R6 feb leap 28", mkTime(23, 59, 59), mkDate(12, 2, 28, 1),
             mkTime(0, 0, 0), mkDate(12, 2, 29, 1));
    rollCase("R6 feb leap 29", mkTime(23, 59, 59), mkDate(12, 2, 29, 1),
             mkTime(0, 0, 0), mkDate(12, 3, 1, 1));
    rollCase("R7 year end", mkTime(23, 59, 59), mkDate(5, 12, 31, 1),
             mkTime(0, 0, 0), mkDate(6, 1, 1, 1));
    rollCase("R13 year wrap", mkTime(23, 59, 59), mkDate(255, 12, 31, 0),
             mkTime(0, 0, 0), mkDate(0, 1, 1, 0));
  endtask

  task automatic testTimeCommit();
    logic [31:0] v;
    setRegs(mkTime(1, 2, 3), mkDate(20, 6, 10, 0));
    wr(A_TIME, mkTime(5, 6, 7));
    for (int i = 0; i < LAT; i++) begin
      rd(A_CTRL, v); chk("R8 busy bit while pending", v, 32'h0000_0100);
      rd(A_TIME, v); chk("R8 old time while pending", v, mkTime(1, 2, 3));
      @(negedge clk);
    end
    rd(A_CTRL, v); chk("R8 busy cleared", v, 32'h0);
    rd(A_TIME, v); chk("R8 new time", v, mkTime(5, 6, 7));
  endtask

  task automatic testDateCommit();
    logic [31:0] v;
    wr(A_DATE, mkDate(33, 11, 9, 1));
    for (int i = 0; i < LAT; i++) begin
      rd(A_CTRL, v); chk("R9 busy bit while pending", v, 32'h0000_0080);
      rd(A_DATE, v); chk("R9 old date while pending", v, mkDate(20, 6, 10, 0));
      @(negedge clk);
    end
    rd(A_CTRL, v); chk("R9 busy cleared", v, 32'h0);
    rd(A_DATE, v); chk("R9 new date", v, mkDate(33, 11, 9, 1));
  endtask

  task automatic testRewrite();
    logic [31:0] v;
    wr(A_TIME, mkTime(8, 8, 8));
    @(negedge clk);
    wr(A_TIME, mkTime(9, 9, 9));
    repeat (LAT - 1) @(negedge clk);
    rd(A_CTRL, v); chk("R10 still busy after restart", v, 32'h0000_0100);
    rd(A_TIME, v); chk("R10 old value held", v, mkTime(5, 6, 7));
    @(negedge clk);
    rd(A_CTRL, v); chk("R10 busy cleared", v, 32'h0);
    rd(A_TIME, v); chk("R10 latest value", v, mkTime(9, 9, 9));
  endtask

  task automatic testCommitTick();
    logic [31:0] v;
    setRegs(mkTime(0, 0, 0), mkDate(7, 3, 14, 0));
    wr(A_TIME, mkTime(23, 59, 59));
    repeat (LAT - 1) @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    rd(A_TIME, v); chk("R11 commit beats tick", v, mkTime(23, 59, 59));
    rd(A_DATE, v); chk("R11 no carry on commit", v, mkDate(7, 3, 14, 0));
  endtask

  task automatic testIgnored();
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R12 ctrl write ignored", v, 32'h0);
    rd(A_TIME, v); chk("R12 time untouched", v, mkTime(23, 59, 59));
    rd(A_DATE, v); chk("R12 date untouched", v, mkDate(7, 3, 14, 0));
    rd(8'h0C, v);  chk("R12 unmapped reads zero", v, 32'h0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTick();
    testLayout();
    testRollover();
    testTimeCommit();
    testDateCommit();
    testRewrite();
    testCommitTick();
    testIgnored();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule